// File: doc/BRIEF.md
# Set-Associative Cache Tag Model

This block replays a stream of memory operations against a cache that holds only tags and replacement state. For every lookup it reports whether the access hit, missed into a free line, or missed and displaced an older line. It also keeps running totals of hits, misses and evictions. The number of set-index bits, block-offset bits and ways are elaboration parameters, so one description covers direct-mapped, multi-way and fully associative arrangements.

Operations enter one per cycle through a valid/ready handshake, each carrying a 2-bit operation code and a byte address. Instruction fetches are accepted and dropped. Loads and stores each make one lookup. A modify makes a load lookup and then a store lookup to the same address, so it yields two result beats and stalls the input for one cycle. No data is stored, and no backing memory or write policy is modelled. Derived figures such as average access time are left to whoever reads the counters.

Top module: `cache_tag_model`

## Requirements
- R1: The address is split, from least significant upward, into OFF_BITS block-offset bits, SET_BITS set-index bits, and the remaining ADDR_W-SET_BITS-OFF_BITS bits as the tag. Addresses that differ only in offset bits map to the same line.
- R2: A lookup hits exactly when a line in the indexed set is valid and holds the address tag.
- R3: A miss in a set that still has an invalid line fills the lowest-numbered invalid way and reports no eviction.
- R4: A miss in a set whose lines are all valid replaces the least recently used line, reports an eviction and increments the eviction counter.
- R5: Every lookup, hit or miss, makes the line it touched the most recently used in its set.
- R6: reqOp encodes 0 = instruction fetch, 1 = load, 2 = store, 3 = modify. An instruction fetch is accepted but produces no result beat and changes no counter or cache state.
- R7: A modify performs a load lookup and then a store lookup to the same address. reqReady is low for exactly the one cycle after a modify is accepted. The second lookup therefore always hits.
- R8: Each lookup produces one result beat on the cycle after it is made. A beat carries resHit, resMiss and resEvict, and resOp repeats the operation code of the request.
- R9: hitCount, missCount and evictCount are CNT_W bits wide. Each counts the beats with the matching flag and holds at its all-ones value instead of wrapping. The counters update on the same edge that raises the matching result beat.
- R10: After reset, every line is invalid, all counters read zero, reqReady is high and resValid is low.
- R11: With SET_BITS = 0, the cache has a single set and any tag may occupy any of the WAYS lines (fully associative).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation offered |
| reqReady | output | 1 | Operation can be accepted this cycle |
| reqOp | input | 2 | Operation code (0 fetch, 1 load, 2 store, 3 modify) |
| reqAddr | input | ADDR_W | Byte address of the operation |
| resValid | output | 1 | Result beat present |
| resHit | output | 1 | Lookup hit |
| resMiss | output | 1 | Lookup missed |
| resEvict | output | 1 | Miss displaced a valid line |
| resOp | output | 2 | Operation code that caused the beat |
| hitCount | output | CNT_W | Saturating hit total |
| missCount | output | CNT_W | Saturating miss total |
| evictCount | output | CNT_W | Saturating eviction total |

## Verification
The bench builds two copies of the block. The first is direct-mapped with 16 sets, 16-byte blocks and 32-bit counters. On that copy it replays a short hand-worked trace whose per-beat outcomes and final totals of 4 hits, 5 misses and 3 evictions follow from the address arithmetic, with an instruction fetch mixed in. The second copy is fully associative with four ways, 4-byte blocks and 4-bit counters. A long pseudo-random sweep over eight tags drives it through every replacement order, every operation code and counter saturation. The expected outcomes come from a recency list kept in the bench.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  typedef enum logic [1:0] {
    OP_IFETCH = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_MODIFY = 2'd3
  } memOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   doLookup;
    memOp_e op;
  } lookupStrobe_t;

endpackage

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] lookupAddr,
  output lookupStrobe_t     strobe
);

  logic              pendStore;
  logic [ADDR_W-1:0] heldAddr;
  logic              accept;

  assign reqReady = !pendStore;
  assign accept   = reqValid && !pendStore;

  always_comb begin
    if (pendStore) begin
      strobe.doLookup = 1'b1;
      strobe.op       = OP_MODIFY;
      lookupAddr      = heldAddr;
    end else begin
      strobe.doLookup = accept && (memOp_e'(reqOp) != OP_IFETCH);
      strobe.op       = memOp_e'(reqOp);
      lookupAddr      = reqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendStore <= 1'b0;
      heldAddr  <= '0;
    end else begin
      pendStore <= accept && (memOp_e'(reqOp) == OP_MODIFY);
      if (accept) heldAddr <= reqAddr;
    end
  end

  // R7
  modify_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd3) |=> !reqReady);

  // R7
  stall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> reqReady);

endmodule

// File: rtl/cache_tags.sv
module cache_tags
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SET_BITS = 2,
  parameter int OFF_BITS = 4,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  lookupStrobe_t     strobe,
  output logic              resValid,
  output logic              resHit,
  output logic              resMiss,
  output logic              resEvict,
  output logic [1:0]        resOp,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  evictCount
);

  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int IDX_W = (SET_BITS > 0) ? SET_BITS : 1;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [WAY_W-1:0] ageQ   [SETS][WAYS];

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] addrTag;
  logic [WAYS-1:0]  hitVec, freeVec, oldVec;
  logic [WAY_W-1:0] hitWay, freeWay, lruWay, fillWay, touchedAge;
  logic             anyHit, anyFree, doEvict;

  generate
    if (SET_BITS > 0) begin : g_indexed
      assign setIdx = lookupAddr[OFF_BITS +: SET_BITS];
    end else begin : g_single
      assign setIdx = '0;
    end
  endgenerate

  assign addrTag = lookupAddr[ADDR_W-1 -: TAG_W];

  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    lruWay  = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w]  = validQ[setIdx][w] && (tagQ[setIdx][w] == addrTag);
      freeVec[w] = !validQ[setIdx][w];
      oldVec[w]  = (ageQ[setIdx][w] == OLDEST);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w])  hitWay  = WAY_W'(w);
      if (freeVec[w]) freeWay = WAY_W'(w);
      if (oldVec[w])  lruWay  = WAY_W'(w);
    end
    anyHit     = |hitVec;
    anyFree    = |freeVec;
    doEvict    = !anyHit && !anyFree;
    fillWay    = anyHit ? hitWay : (anyFree ? freeWay : lruWay);
    touchedAge = ageQ[setIdx][fillWay];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tagQ[s][w] <= '0;
          ageQ[s][w] <= WAY_W'(w);
        end
      end
    end else if (strobe.doLookup) begin
      validQ[setIdx][fillWay] <= 1'b1;
      tagQ[setIdx][fillWay]   <= addrTag;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == fillWay)
          ageQ[setIdx][w] <= '0;
        else if (ageQ[setIdx][w] < touchedAge)
          ageQ[setIdx][w] <= ageQ[setIdx][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resHit     <= 1'b0;
      resMiss    <= 1'b0;
      resEvict   <= 1'b0;
      resOp      <= '0;
      hitCount   <= '0;
      missCount  <= '0;
      evictCount <= '0;
    end else begin
      resValid <= strobe.doLookup;
      resHit   <= strobe.doLookup && anyHit;
      resMiss  <= strobe.doLookup && !anyHit;
      resEvict <= strobe.doLookup && doEvict;
      resOp    <= strobe.op;
      if (strobe.doLookup) begin
        if (anyHit && hitCount != '1)    hitCount   <= hitCount + 1'b1;
        if (!anyHit && missCount != '1)  missCount  <= missCount + 1'b1;
        if (doEvict && evictCount != '1) evictCount <= evictCount + 1'b1;
      end
    end
  end

  // R4
  single_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doLookup && doEvict) |-> ($countones(oldVec) == 1));

  // R4
  evict_is_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resEvict) |-> resMiss);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ##1 ((hitCount - $past(hitCount)) <= 1) && ((missCount - $past(missCount)) <= 1)
        && ((evictCount - $past(evictCount)) <= 1));

endmodule

// File: rtl/cache_tag_model.sv
module cache_tag_model
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SET_BITS = 2,
  parameter int OFF_BITS = 4,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              resValid,
  output logic              resHit,
  output logic              resMiss,
  output logic              resEvict,
  output logic [1:0]        resOp,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic [CNT_W-1:0]  evictCount
);

  logic [ADDR_W-1:0] lookupAddr;
  lookupStrobe_t     strobe;

  cache_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .lookupAddr(lookupAddr), .strobe(strobe)
  );

  cache_tags #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS),
    .WAYS(WAYS), .CNT_W(CNT_W)
  ) u_tags (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .strobe(strobe),
    .resValid(resValid), .resHit(resHit), .resMiss(resMiss),
    .resEvict(resEvict), .resOp(resOp), .hitCount(hitCount),
    .missCount(missCount), .evictCount(evictCount)
  );

  // R8
  fetch_no_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd0) |=> !resValid);

  // R8
  lookup_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp != 2'd0) |=> (resValid && resOp == $past(reqOp)));

endmodule

// File: tb/cache_tag_model_bench.sv
`timescale 1ns/1ps
module cache_tag_model_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // direct-mapped copy: 16 sets, 16-byte blocks, 1 way
  logic        aValid = 1'b0;
  logic [1:0]  aOp = '0;
  logic [15:0] aAddr = '0;
  logic        aReady, aResValid, aHit, aMiss, aEvict;
  logic [1:0]  aResOp;
  logic [31:0] aHits, aMisses, aEvicts;

  // fully associative copy: 1 set, 4-byte blocks, 4 ways, 4-bit counters
  logic        bValid = 1'b0;
  logic [1:0]  bOp = '0;
  logic [11:0] bAddr = '0;
  logic        bReady, bResValid, bHit, bMiss, bEvict;
  logic [1:0]  bResOp;
  logic [3:0]  bHits, bMisses, bEvicts;

  cache_tag_model #(.ADDR_W(16), .SET_BITS(4), .OFF_BITS(4), .WAYS(1), .CNT_W(32)) u_cache_tag_model (
    .clk(clk), .rstN(rstN), .reqValid(aValid), .reqReady(aReady), .reqOp(aOp),
    .reqAddr(aAddr), .resValid(aResValid), .resHit(aHit), .resMiss(aMiss),
    .resEvict(aEvict), .resOp(aResOp), .hitCount(aHits), .missCount(aMisses),
    .evictCount(aEvicts)
  );

  cache_tag_model #(.ADDR_W(12), .SET_BITS(0), .OFF_BITS(2), .WAYS(4), .CNT_W(4)) u_cache_tag_model_fa (
    .clk(clk), .rstN(rstN), .reqValid(bValid), .reqReady(bReady), .reqOp(bOp),
    .reqAddr(bAddr), .resValid(bResValid), .resHit(bHit), .resMiss(bMiss),
    .resEvict(bEvict), .resOp(bResOp), .hitCount(bHits), .missCount(bMisses),
    .evictCount(bEvicts)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one operation on the direct-mapped copy; e1/e2 = {hit,miss,evict}
  task automatic runA(input int op, input int addr, input bit [2:0] e1, input bit [2:0] e2);
    @(negedge clk);
    chk("R7", "ready before issue", aReady, 1);
    aValid = 1'b1; aOp = 2'(op); aAddr = 16'(addr);
    @(negedge clk);
    aValid = 1'b0;
    if (op == 0) begin
      chk("R6", "fetch gives no beat", aResValid, 0);
    end else begin
      chk("R8", "beat1 valid", aResValid, 1);
      chk("R8", "beat1 op", aResOp, op);
      chk("R2", "beat1 hit", aHit, e1[2]);
      chk("R3", "beat1 miss", aMiss, e1[1]);
      chk("R4", "beat1 evict", aEvict, e1[0]);
      if (op == 3) begin
        chk("R7", "ready low during modify", aReady, 0);
        @(negedge clk);
        chk("R7", "beat2 valid", aResValid, 1);
        chk("R7", "beat2 op", aResOp, 3);
        chk("R7", "beat2 hit", aHit, e2[2]);
        chk("R7", "beat2 miss", aMiss, e2[1]);
        chk("R7", "beat2 evict", aEvict, e2[0]);
        chk("R7", "ready back", aReady, 1);
      end
    end
  endtask

  // recency list for the fully associative copy, most recent first
  int mru[4];
  int nUsed = 0;
  int expHits = 0, expMisses = 0, expEvicts = 0;

  task automatic refLookup(input int t, output bit h, output bit ev);
    int pos;
    pos = -1;
    for (int i = 0; i < nUsed; i++) if (mru[i] == t) pos = i;
    h = (pos >= 0);
    ev = 1'b0;
    if (!h) begin
      if (nUsed == 4) begin ev = 1'b1; pos = 3; end
      else begin pos = nUsed; nUsed++; end
    end
    for (int i = pos; i > 0; i--) mru[i] = mru[i-1];
    mru[0] = t;
    if (h) expHits++; else expMisses++;
    if (ev) expEvicts++;
  endtask

  function automatic int sat15(input int x);
    return (x > 15) ? 15 : x;
  endfunction

  task automatic runB(input int op, input int tag, input int off);
    bit h1, ev1, h2, ev2;
    h1 = 0; ev1 = 0; h2 = 0; ev2 = 0;
    @(negedge clk);
    bValid = 1'b1; bOp = 2'(op); bAddr = 12'((tag << 2) | off);
    if (op != 0) refLookup(tag, h1, ev1);
    if (op == 3) refLookup(tag, h2, ev2);
    @(negedge clk);
    bValid = 1'b0;
    if (op == 0) begin
      chk("R6", "fa fetch no beat", bResValid, 0);
    end else begin
      chk("R8", "fa beat valid", bResValid, 1);
      chk("R5", "fa hit", bHit, h1);
      chk("R4", "fa evict", bEvict, ev1);
      chk("R11", "fa miss", bMiss, !h1);
      if (op == 3) begin
        @(negedge clk);
        chk("R7", "fa second beat hit", bHit, h2);
        chk("R7", "fa second beat op", bResOp, 3);
      end
    end
    chk("R9", "fa hits", bHits, sat15(expHits));
    chk("R9", "fa misses", bMisses, sat15(expMisses));
    chk("R9", "fa evicts", bEvicts, sat15(expEvicts));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "ready", aReady, 1);
    chk("R10", "resValid", aResValid, 0);
    chk("R10", "hits", aHits, 0);
    chk("R10", "misses", aMisses, 0);
    chk("R10", "evicts", aEvicts, 0);
    rstN = 1'b1;

    // R1 direct-mapped trace: offset 4 bits, set 4 bits, tag above
    runA(1, 'h010, 3'b010, 3'b000);
    runA(3, 'h020, 3'b010, 3'b100);
    runA(0, 'h110, 3'b000, 3'b000);   // fetch to a conflicting line: ignored
    runA(1, 'h022, 3'b100, 3'b000);
    runA(2, 'h018, 3'b100, 3'b000);   // R1 same line as 0x10
    chk("R6", "counts after fetch hits", aHits, 3);
    chk("R6", "counts after fetch misses", aMisses, 2);
    runA(1, 'h110, 3'b011, 3'b000);
    runA(1, 'h210, 3'b011, 3'b000);
    runA(3, 'h012, 3'b011, 3'b100);
    @(negedge clk);
    chk("R9", "trace hits", aHits, 4);
    chk("R9", "trace misses", aMisses, 5);
    chk("R9", "trace evicts", aEvicts, 3);

    // R11 fully associative sweep with R5 recency order
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int n = 0; n < 500; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        runB(int'(lfsr[1:0]), int'(lfsr[6:4]), int'(lfsr[9:8]));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule